// File: doc/BRIEF.md
# Minimal-Flag 8-bit ALU

This block is an 8-bit arithmetic and logic unit for a datapath built with very few gates. It holds an accumulator and a temporary register. It adds, subtracts and applies bitwise logic to one of those registers and a byte taken from the data bus. It shifts left by feeding the chosen register into both adder inputs. The adder is a chain of narrow ripple slices. With the default parameters it is two 4-bit slices.

Only three flags live in hardware. These are negative, carry, and an internal carry kept for address or multi-byte work that must not disturb the user carry. The block has no zero-detect gate and no overflow logic. It presents the raw result byte and the three sign bits that decide overflow. Surrounding logic can store them and evaluate zero or overflow later, only when it needs them.

A control unit drives the function code, the carry-in choice, the operand choice and the write enables every cycle. The result and the sign-bit tap are combinational in that cycle. Register and flag writes take effect at the next rising clock edge.

Top module: `min_flag_alu`

## Requirements
- R1: While `rst_n` is low, the accumulator, the temporary register and the flags N, C and TC all read 0.
- R2: With `func` = 1 (add), `result` equals (A + bus_in + cin) mod 256, and the carry-out is bit 8 of that sum. A is the accumulator when `a_sel` = 0 and the temporary register when `a_sel` = 1.
- R3: `cin_sel` picks the adder carry-in: 0 gives 0, 1 gives 1, 2 gives the C flag and 3 gives the TC flag.
- R4: With `func` = 6 (subtract), `result` equals (A + ~bus_in + cin) mod 256 and the carry-out is bit 8 of that sum. With cin = 1 this is A − bus_in, and carry-out is 1 when there is no borrow.
- R5: With `func` = 2 (shift left), `result` equals (A + A + cin) mod 256 and the carry-out equals A bit 7. The bus byte is not used.
- R6: `func` = 3, 4 and 5 give A AND bus_in, A OR bus_in and A XOR bus_in. `func` = 0 passes bus_in through and `func` = 7 passes A through. For all five, the carry-out is 0.
- R7: When `flag_we` is high, N takes result bit 7 and C takes the carry-out at the next rising edge. When `flag_we` is low, both hold.
- R8: TC takes the carry-out at the next rising edge only when `tc_we` is high. Otherwise it holds, whatever `flag_we` does.
- R9: `acc_we` and `t_we` each load `result` into their register at the next rising edge. A register whose enable is low keeps its value, so writing the temporary register leaves the accumulator unchanged.
- R10: `ovf_bits` = {A bit 7, adder B-input bit 7, result bit 7}. The adder B-input is bus_in, its inverse for subtract, or A for shift. For add and subtract, signed overflow equals (ovf_bits[2] == ovf_bits[1]) && (ovf_bits[0] != ovf_bits[2]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Operand byte from the data bus |
| func | input | 3 | Function code (0 pass bus, 1 add, 2 shift left, 3 and, 4 or, 5 xor, 6 subtract, 7 pass A) |
| cin_sel | input | 2 | Carry-in choice (0 zero, 1 one, 2 C, 3 TC) |
| a_sel | input | 1 | Operand A choice: 0 accumulator, 1 temporary register |
| acc_we | input | 1 | Load result into the accumulator |
| t_we | input | 1 | Load result into the temporary register |
| flag_we | input | 1 | Load N and C |
| tc_we | input | 1 | Load TC |
| result | output | 8 | Combinational result byte |
| acc_out | output | 8 | Accumulator contents |
| t_out | output | 8 | Temporary register contents |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_tc | output | 1 | Internal carry flag |
| ovf_bits | output | 3 | Sign bits for deferred overflow: {A7, B7, R7} |

## Verification
`result` and `ovf_bits` follow the inputs in the same cycle with no register on the path. The bench drives at the falling edge and samples them 1 ns later, before the next rising edge. The accumulator, the temporary register and the three flags change at the next rising edge. The bench reads them at the falling edge after that edge and compares them with a model that it updates only when the matching enable was high. Add and subtract are swept over every bus byte against sixteen A values and both fixed carry-ins. Shift is swept over every A value, and the logic functions over every bus byte. A random phase mixes the C and TC carry-in sources with independent enables.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    FN_PASSB = 3'd0,
    FN_ADD   = 3'd1,
    FN_SHL   = 3'd2,
    FN_AND   = 3'd3,
    FN_OR    = 3'd4,
    FN_XOR   = 3'd5,
    FN_SUB   = 3'd6,
    FN_PASSA = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_C    = 2'd2,
    CI_TC   = 2'd3
  } cin_sel_e;
endpackage

// File: rtl/alu_nibble_add.sv
module alu_nibble_add #(
  parameter int SLICE = 4
) (
  input  logic [SLICE-1:0] a,
  input  logic [SLICE-1:0] b,
  input  logic             ci,
  output logic [SLICE-1:0] s,
  output logic             co
);
  // One ripple slice of the adder chain.
  assign {co, s} = {1'b0, a} + {1'b0, b} + {{SLICE{1'b0}}, ci};
endmodule

// File: rtl/alu_adder_chain.sv
module alu_adder_chain #(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  localparam int NSLICE = WIDTH / SLICE;

  logic [NSLICE:0] carry;
  assign carry[0] = ci;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    alu_nibble_add #(.SLICE(SLICE)) u_add (
      .a  (a[g*SLICE +: SLICE]),
      .b  (b[g*SLICE +: SLICE]),
      .ci (carry[g]),
      .s  (s[g*SLICE +: SLICE]),
      .co (carry[g+1])
    );
  end

  assign co = carry[NSLICE];
endmodule

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_we,
  input  logic tc_we,
  input  logic res_msb,
  input  logic cout,
  output logic flag_n,
  output logic flag_c,
  output logic flag_tc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_c <= 1'b0;
    end else if (flag_we) begin
      flag_n <= res_msb;
      flag_c <= cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_tc <= 1'b0;
    else if (tc_we) flag_tc <= cout;
  end

  p_nc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ($stable(flag_n) && $stable(flag_c)));
  p_nc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_n == $past(res_msb) && flag_c == $past(cout)));
  p_tc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_we |=> $stable(flag_tc));
endmodule

// File: rtl/min_flag_alu.sv
module min_flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_in,
  input  logic [2:0]       func,
  input  logic [1:0]       cin_sel,
  input  logic             a_sel,
  input  logic             acc_we,
  input  logic             t_we,
  input  logic             flag_we,
  input  logic             tc_we,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] acc_out,
  output logic [WIDTH-1:0] t_out,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_tc,
  output logic [2:0]       ovf_bits
);
  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn;
  cin_sel_e         csel;
  logic [WIDTH-1:0] acc_q, t_q, a_op, add_b, sum;
  logic             cin, add_co, cout, is_arith;

  assign fn   = alu_fn_e'(func);
  assign csel = cin_sel_e'(cin_sel);
  assign a_op = a_sel ? t_q : acc_q;

  // Adder B input: bus, inverted bus for subtract, operand A for shift.
  always_comb begin
    unique case (fn)
      FN_SUB:  add_b = ~bus_in;
      FN_SHL:  add_b = a_op;
      default: add_b = bus_in;
    endcase
  end

  always_comb begin
    unique case (csel)
      CI_ZERO: cin = 1'b0;
      CI_ONE:  cin = 1'b1;
      CI_C:    cin = flag_c;
      default: cin = flag_tc;
    endcase
  end

  alu_adder_chain #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chain (
    .a  (a_op),
    .b  (add_b),
    .ci (cin),
    .s  (sum),
    .co (add_co)
  );

  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_SHL);

  always_comb begin
    unique case (fn)
      FN_PASSB: result = bus_in;
      FN_AND:   result = a_op & bus_in;
      FN_OR:    result = a_op | bus_in;
      FN_XOR:   result = a_op ^ bus_in;
      FN_PASSA: result = a_op;
      default:  result = sum;
    endcase
  end

  assign cout     = is_arith ? add_co : 1'b0;
  assign ovf_bits = {a_op[MSB], add_b[MSB], result[MSB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_we) acc_q <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else if (t_we) t_q <= result;
  end

  assign acc_out = acc_q;
  assign t_out   = t_q;

  alu_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_we (flag_we),
    .tc_we   (tc_we),
    .res_msb (result[MSB]),
    .cout    (cout),
    .flag_n  (flag_n),
    .flag_c  (flag_c),
    .flag_tc (flag_tc)
  );

  p_sum_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_ADD || fn == FN_SUB) |->
      ({cout, result} == ({1'b0, a_op} + {1'b0, add_b} + {{WIDTH{1'b0}}, cin})));
  p_shl_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_SHL) |-> (cout == a_op[MSB]));
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(acc_q));
  p_t_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |=> (t_q == $past(result)));
endmodule

// File: tb/min_flag_alu_tb_top.sv
`timescale 1ns/1ps
module min_flag_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic [2:0] func = '0;
  logic [1:0] cin_sel = '0;
  logic       a_sel = 1'b0, acc_we = 1'b0, t_we = 1'b0, flag_we = 1'b0, tc_we = 1'b0;
  logic [7:0] result, acc_out, t_out;
  logic       flag_n, flag_c, flag_tc;
  logic [2:0] ovf_bits;

  int tests = 0;
  int fails = 0;
  logic [7:0] m_acc = '0, m_t = '0;
  logic       m_n = 1'b0, m_c = 1'b0, m_tc = 1'b0;

  always #2.5 clk = ~clk;

  min_flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .func(func), .cin_sel(cin_sel),
    .a_sel(a_sel), .acc_we(acc_we), .t_we(t_we), .flag_we(flag_we), .tc_we(tc_we),
    .result(result), .acc_out(acc_out), .t_out(t_out), .flag_n(flag_n),
    .flag_c(flag_c), .flag_tc(flag_tc), .ovf_bits(ovf_bits)
  );

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [2:0] f, input logic [7:0] a,
                                       input logic [7:0] b, input logic ci);
    case (f)
      3'd0: model = {1'b0, b};
      3'd1: model = {1'b0, a} + {1'b0, b} + {8'd0, ci};
      3'd2: model = {1'b0, a} + {1'b0, a} + {8'd0, ci};
      3'd3: model = {1'b0, a & b};
      3'd4: model = {1'b0, a | b};
      3'd5: model = {1'b0, a ^ b};
      3'd6: model = {1'b0, a} + {1'b0, ~b} + {8'd0, ci};
      default: model = {1'b0, a};
    endcase
  endfunction

  // Called just after a falling edge; returns after the next falling edge.
  task automatic step(input logic [2:0] f, input logic [1:0] cs, input logic as,
                      input logic [7:0] b, input logic aw, input logic tw,
                      input logic fw, input logic tcw, input string tag);
    logic [7:0] a, beff;
    logic       ci;
    logic [8:0] e;
    int         ssum;
    a  = as ? m_t : m_acc;
    ci = (cs == 2'd0) ? 1'b0 : (cs == 2'd1) ? 1'b1 : (cs == 2'd2) ? m_c : m_tc;
    e  = model(f, a, b, ci);
    beff = (f == 3'd6) ? ~b : (f == 3'd2) ? a : b;
    func = f; cin_sel = cs; a_sel = as; bus_in = b;
    acc_we = aw; t_we = tw; flag_we = fw; tc_we = tcw;
    #1;
    chk({1'b0, result}, {1'b0, e[7:0]}, tag);
    chk({6'd0, ovf_bits}, {6'd0, a[7], beff[7], e[7]}, "R10 ovf_bits");
    if (f == 3'd1 || f == 3'd6) begin
      ssum = int'($signed(a)) + int'($signed(beff)) + int'(ci);
      chk({8'd0, (ovf_bits[2] == ovf_bits[1]) && (ovf_bits[0] != ovf_bits[2])},
          {8'd0, (ssum > 127) || (ssum < -128)}, "R10 overflow derivation");
    end
    @(posedge clk);
    if (aw) m_acc = e[7:0];
    if (tw) m_t = e[7:0];
    if (fw) begin m_n = e[7]; m_c = e[8]; end
    if (tcw) m_tc = e[8];
    @(negedge clk);
    chk({1'b0, acc_out}, {1'b0, m_acc}, "R9 accumulator");
    chk({1'b0, t_out}, {1'b0, m_t}, "R9 temp register");
    chk({8'd0, flag_n}, {8'd0, m_n}, "R7 N flag");
    chk({8'd0, flag_c}, {8'd0, m_c}, {"R7 C flag / ", tag});
    chk({8'd0, flag_tc}, {8'd0, m_tc}, {"R8 TC flag / ", tag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, with enables held high to show reset dominates
    acc_we = 1'b1; t_we = 1'b1; flag_we = 1'b1; tc_we = 1'b1; bus_in = 8'hFF;
    @(negedge clk);
    chk({1'b0, acc_out}, 9'h0, "R1 reset acc");
    chk({1'b0, t_out}, 9'h0, "R1 reset T");
    chk({6'd0, flag_n, flag_c, flag_tc}, 9'h0, "R1 reset flags");
    acc_we = 1'b0; t_we = 1'b0; flag_we = 1'b0; tc_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2 add and R4 subtract sweeps
    for (int fi = 0; fi < 2; fi++) begin
      for (int ai = 0; ai < 16; ai++) begin
        step(3'd0, 2'd0, 1'b0, 8'(ai * 17), 1'b1, 1'b0, 1'b0, 1'b0, "R6 pass bus");
        for (int b = 0; b < 256; b++)
          for (int c = 0; c < 2; c++)
            step(fi == 0 ? 3'd1 : 3'd6, 2'(c), 1'b0, 8'(b), 1'b0, 1'b0, 1'b1, 1'b1,
                 fi == 0 ? "R2 add" : "R4 subtract");
      end
    end

    // R5 shift left through the temporary register, carry-in 0 and C
    for (int a = 0; a < 256; a++) begin
      step(3'd0, 2'd0, 1'b0, 8'(a), 1'b0, 1'b1, 1'b0, 1'b0, "R6 pass bus to T");
      step(3'd2, 2'd0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "R5 shift left");
      step(3'd2, 2'd2, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, "R5 shift with C");
    end

    // R6 logic and pass functions
    for (int ai = 0; ai < 16; ai++) begin
      step(3'd0, 2'd0, 1'b0, 8'(ai * 16 + 15 - ai), 1'b1, 1'b0, 1'b0, 1'b0, "R6 load");
      for (int b = 0; b < 256; b++) begin
        step(3'd3, 2'd1, 1'b0, 8'(b), 1'b0, 1'b0, 1'b1, 1'b1, "R6 and");
        step(3'd4, 2'd1, 1'b0, 8'(b), 1'b0, 1'b0, 1'b1, 1'b0, "R6 or");
        step(3'd5, 2'd1, 1'b0, 8'(b), 1'b0, 1'b0, 1'b1, 1'b1, "R6 xor");
        step(3'd7, 2'd1, 1'b0, 8'(b), 1'b0, 1'b0, 1'b1, 1'b0, "R6 pass A");
      end
    end

    // R3 carry sources, R7/R8/R9 independent enables
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0], r[4:3], r[5], r[15:8], r[16], r[17], r[18], r[19],
           "R3 carry select mix");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule